// File: doc/BRIEF.md
# Ping-Pong Phase-Event PWM Sequencer

This block turns lists of phase-stamped switching events into PWM output patterns. Each of two identical event players walks through its own memory segment of records. A record says "when the phase index reaches this angle, drive this level pattern". A phase source outside the block supplies a phase index in tenth-degree units (0 to 3599) together with a step strobe. On a strobe whose index equals the phase of the record a player is holding, the player applies that record's levels and moves on to the following record. A flag bit marks the last record of a segment. After that record the player wraps back to the start of its segment.

In independent mode the players run separately: player 0 drives channel group A and player 1 drives channel group B, each started and stopped by its own run input. In alternate mode both players serve group A and only one of them is connected at a time. While one player plays, software rewrites the other segment and then issues a switch request. The handover is deferred until the playing player has applied the last record of its segment. The other player, which has reloaded its segment from the start after the request, then takes over. Group B is held low in this mode.

Each player reads its memory through a synchronous port with one cycle of latency. It keeps a second record prefetched, so events on adjacent phase steps are both honoured.

Top module: `pingpong_pwm_seq`

## Requirements
- R1: A record is 21 bits: bit 20 is the end-of-segment flag, bits 19:8 the 12-bit phase, bits 7:0 the level pattern.
- R2: After reset chanA, chanB and altSel are 0 and no memory read is issued.
- R3: In the cycle a player becomes enabled it issues a read of address 0. Reads then follow sequentially, and each read returns data on the next cycle.
- R4: On a cycle with phaseStep high and phaseIdx equal to the held record's phase, that record's level appears on the player's channel group one cycle later. The player then holds the next record.
- R5: With phase steps at least two cycles apart, records on consecutive steps are all applied, each at its own step.
- R6: After applying a record with the end flag set, a player continues with the record at address 0. Addresses also wrap after 63.
- R7: With altMode 0, player 0 is enabled by runA and drives chanA, and player 1 is enabled by runB and drives chanB, with no interaction between them.
- R8: With altMode 1, runA enables the pair, player 0 is active first (altSel 0), runB is ignored, and chanB is held at 0.
- R9: In alternate mode a switch request takes effect only when the active player applies an end-flagged record. altSel toggles on the following cycle, and until then the standby player changes nothing on chanA.
- R10: A switch request makes the standby player load its segment from address 0, so after the handover it plays the segment's current contents.
- R11: A switch request that arrives while an earlier one is still pending is absorbed, so only one handover results.
- R12: Without a phase step, or on a step whose index matches no held record, the channel outputs keep their values.
- R13: Dropping a player's enable stops its reads and discards its position. A later enable restarts from address 0. In alternate mode, dropping runA also returns altSel to 0 and clears a pending switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| altMode | input | 1 | 1 = alternate (ping-pong) mode, 0 = independent |
| runA | input | 1 | Enable of player 0, or of the pair in alternate mode |
| runB | input | 1 | Enable of player 1 in independent mode |
| switchReq | input | 1 | Single-cycle buffer switch request (alternate mode) |
| phaseIdx | input | 12 | Current phase index |
| phaseStep | input | 1 | Strobe marking a new phase index |
| memRdA | output | 1 | Read enable, segment of player 0 |
| memAddrA | output | 6 | Read address, segment of player 0 |
| memDataA | input | 21 | Read data (one cycle after the read), player 0 |
| memRdB | output | 1 | Read enable, segment of player 1 |
| memAddrB | output | 6 | Read address, segment of player 1 |
| memDataB | input | 21 | Read data (one cycle after the read), player 1 |
| chanA | output | 8 | Channel group A levels |
| chanB | output | 8 | Channel group B levels |
| altSel | output | 1 | Player connected to group A in alternate mode |

## Verification
The hardest state to reach is a deferred handover with a second request already absorbed. The active player must be partway through its segment, a request must be pending, and the standby segment must have been rewritten. The stimulus issues two switch requests in a row after the first record of a three-record segment. It then steps the phase past an event that belongs only to the standby segment, to show nothing moves early. Only after that does it reach the end-flagged record. The segment the player hands back is then refilled with a new one-record list before the next request, which shows that the reload reads fresh contents.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic [1:0] fetchEn;   // player may read its segment
    logic [1:0] matchEn;   // player may compare and apply
    logic       altRoute;  // alternate routing of outputs
    logic       altSel;    // player routed to group A
  } seqCtl_t;

  // Events from the datapath back to the control.
  typedef struct packed {
    logic [1:0] applied;      // a record was applied this cycle
    logic [1:0] appliedLast;  // the applied record closes its segment
  } seqEvt_t;

endpackage

// File: rtl/pps_player.sv
module pps_player #(
  parameter int PHASE_W = 12,
  parameter int LEVEL_W = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              fetchEn,
  input  logic                              matchEn,
  input  logic [PHASE_W-1:0]                phaseIdx,
  input  logic                              phaseStep,
  output logic                              memRd,
  output logic [ADDR_W-1:0]                 memAddr,
  input  logic [PHASE_W+LEVEL_W:0]          memData,
  output logic                              applied,
  output logic                              appliedLast,
  output logic [LEVEL_W-1:0]                appliedLevel
);

  localparam int REC_W   = PHASE_W + LEVEL_W + 1;
  localparam int END_BIT = REC_W - 1;

  logic [REC_W-1:0]  curRec, nxtRec;
  logic              curV, nxtV, rdPend;
  logic [ADDR_W-1:0] nextAddr;

  logic [PHASE_W-1:0] curPhase;
  logic               hit;
  logic [REC_W-1:0]   keepCur;
  logic               keepCurV, keepNxtV;

  assign curPhase     = curRec[PHASE_W+LEVEL_W-1:LEVEL_W];
  assign hit          = matchEn && phaseStep && curV && (curPhase == phaseIdx);
  assign applied      = hit;
  assign appliedLast  = hit && curRec[END_BIT];
  assign appliedLevel = curRec[LEVEL_W-1:0];

  // one read in flight at most; a slot must be free
  assign memRd   = fetchEn && !rdPend && !(curV && nxtV);
  assign memAddr = nextAddr;

  // holding registers after a possible consume
  always_comb begin
    if (hit) begin
      keepCur  = nxtRec;
      keepCurV = nxtV;
      keepNxtV = 1'b0;
    end else begin
      keepCur  = curRec;
      keepCurV = curV;
      keepNxtV = nxtV;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !fetchEn) begin
      curRec   <= '0;
      nxtRec   <= '0;
      curV     <= 1'b0;
      nxtV     <= 1'b0;
      rdPend   <= 1'b0;
      nextAddr <= '0;
    end else begin
      rdPend <= memRd;
      if (rdPend) begin
        nextAddr <= memData[END_BIT] ? '0 : nextAddr + 1'b1;
        if (!keepCurV) begin
          curRec <= memData;
          curV   <= 1'b1;
          nxtV   <= 1'b0;
        end else begin
          curRec <= keepCur;
          curV   <= 1'b1;
          nxtRec <= memData;
          nxtV   <= 1'b1;
        end
      end else begin
        curRec <= keepCur;
        curV   <= keepCurV;
        nxtV   <= keepNxtV;
      end
    end
  end

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int LEVEL_W = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  seqCtl_t                                ctl,
  input  logic [PHASE_W-1:0]                     phaseIdx,
  input  logic                                   phaseStep,
  output logic [1:0]                             memRd,
  output logic [1:0][ADDR_W-1:0]                 memAddr,
  input  logic [1:0][PHASE_W+LEVEL_W:0]          memData,
  output seqEvt_t                                evt,
  output logic [LEVEL_W-1:0]                     chanA,
  output logic [LEVEL_W-1:0]                     chanB
);

  logic [1:0]              applied, appliedLast;
  logic [1:0][LEVEL_W-1:0] level;

  for (genvar g = 0; g < 2; g++) begin : g_player
    pps_player #(
      .PHASE_W(PHASE_W),
      .LEVEL_W(LEVEL_W),
      .ADDR_W (ADDR_W)
    ) u_player (
      .clk         (clk),
      .rstN        (rstN),
      .fetchEn     (ctl.fetchEn[g]),
      .matchEn     (ctl.matchEn[g]),
      .phaseIdx    (phaseIdx),
      .phaseStep   (phaseStep),
      .memRd       (memRd[g]),
      .memAddr     (memAddr[g]),
      .memData     (memData[g]),
      .applied     (applied[g]),
      .appliedLast (appliedLast[g]),
      .appliedLevel(level[g])
    );
  end

  assign evt.applied     = applied;
  assign evt.appliedLast = appliedLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanA <= '0;
      chanB <= '0;
    end else if (ctl.altRoute) begin
      if (ctl.altSel ? applied[1] : applied[0])
        chanA <= ctl.altSel ? level[1] : level[0];
      chanB <= '0;
    end else begin
      if (applied[0]) chanA <= level[0];
      if (applied[1]) chanB <= level[1];
    end
  end

endmodule

// File: rtl/pps_control.sv
module pps_control
  import pps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    altMode,
  input  logic    runA,
  input  logic    runB,
  input  logic    switchReq,
  input  seqEvt_t evt,
  output seqCtl_t ctl,
  output logic    altSel
);

  logic altRun, pend, sel, lastHit;

  assign altRun  = altMode && runA;
  assign lastHit = sel ? evt.appliedLast[1] : evt.appliedLast[0];

  always_comb begin
    ctl.altRoute = altMode;
    ctl.altSel   = sel;
    if (altMode) begin
      ctl.fetchEn[0] = altRun && (!sel || pend);
      ctl.fetchEn[1] = altRun && (sel || pend);
      ctl.matchEn[0] = altRun && !sel;
      ctl.matchEn[1] = altRun && sel;
    end else begin
      ctl.fetchEn[0] = runA;
      ctl.fetchEn[1] = runB;
      ctl.matchEn[0] = runA;
      ctl.matchEn[1] = runB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !altRun) begin
      sel  <= 1'b0;
      pend <= 1'b0;
    end else if (pend && lastHit) begin
      sel  <= !sel;
      pend <= 1'b0;
    end else if (switchReq) begin
      pend <= 1'b1;
    end
  end

  assign altSel = sel;

endmodule

// File: rtl/pingpong_pwm_seq.sv
module pingpong_pwm_seq
  import pps_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int LEVEL_W = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       altMode,
  input  logic                       runA,
  input  logic                       runB,
  input  logic                       switchReq,
  input  logic [PHASE_W-1:0]         phaseIdx,
  input  logic                       phaseStep,
  output logic                       memRdA,
  output logic [ADDR_W-1:0]          memAddrA,
  input  logic [PHASE_W+LEVEL_W:0]   memDataA,
  output logic                       memRdB,
  output logic [ADDR_W-1:0]          memAddrB,
  input  logic [PHASE_W+LEVEL_W:0]   memDataB,
  output logic [LEVEL_W-1:0]         chanA,
  output logic [LEVEL_W-1:0]         chanB,
  output logic                       altSel
);

  seqCtl_t ctl;
  seqEvt_t evt;
  logic [1:0]                     memRd;
  logic [1:0][ADDR_W-1:0]         memAddr;
  logic [1:0][PHASE_W+LEVEL_W:0]  memData;

  assign memData  = {memDataB, memDataA};
  assign memRdA   = memRd[0];
  assign memRdB   = memRd[1];
  assign memAddrA = memAddr[0];
  assign memAddrB = memAddr[1];

  pps_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .altMode  (altMode),
    .runA     (runA),
    .runB     (runB),
    .switchReq(switchReq),
    .evt      (evt),
    .ctl      (ctl),
    .altSel   (altSel)
  );

  pps_datapath #(
    .PHASE_W(PHASE_W),
    .LEVEL_W(LEVEL_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .phaseIdx (phaseIdx),
    .phaseStep(phaseStep),
    .memRd    (memRd),
    .memAddr  (memAddr),
    .memData  (memData),
    .evt      (evt),
    .chanA    (chanA),
    .chanB    (chanB)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int LEVEL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               altMode,
  input logic               runA,
  input logic               runB,
  input logic               phaseStep,
  input logic               memRdA,
  input logic               memRdB,
  input logic [LEVEL_W-1:0] chanA,
  input logic [LEVEL_W-1:0] chanB,
  input logic               altSel
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r12_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(phaseStep) |-> $stable(chanA));

  a_r8_group_b_low: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(altMode) |-> chanB == '0);

  a_r9_sel_moves_on_step: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && !$past(phaseStep) && $past(altMode && runA) |-> $stable(altSel));

  a_r13_pair_stopped: assert property (@(posedge clk) disable iff (!rstN)
    altMode && !runA |-> !memRdA && !memRdB);

  a_r7_player_b_off: assert property (@(posedge clk) disable iff (!rstN)
    !altMode && !runB |-> !memRdB);

endmodule

bind pingpong_pwm_seq pps_checker #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .altMode  (altMode),
  .runA     (runA),
  .runB     (runB),
  .phaseStep(phaseStep),
  .memRdA   (memRdA),
  .memRdB   (memRdB),
  .chanA    (chanA),
  .chanB    (chanB),
  .altSel   (altSel)
);

// File: tb/sim_pingpong_pwm_seq.sv
`timescale 1ns/1ps
module sim_pingpong_pwm_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        altMode = 1'b0, runA = 1'b0, runB = 1'b0, switchReq = 1'b0;
  logic [11:0] phaseIdx = '0;
  logic        phaseStep = 1'b0;
  logic        memRdA, memRdB;
  logic [5:0]  memAddrA, memAddrB;
  logic [20:0] memDataA = '0, memDataB = '0;
  logic [7:0]  chanA, chanB;
  logic        altSel;

  always #10 clk = ~clk;  // 50 MHz

  pingpong_pwm_seq u0 (
    .clk(clk), .rstN(rstN), .altMode(altMode), .runA(runA), .runB(runB),
    .switchReq(switchReq), .phaseIdx(phaseIdx), .phaseStep(phaseStep),
    .memRdA(memRdA), .memAddrA(memAddrA), .memDataA(memDataA),
    .memRdB(memRdB), .memAddrB(memAddrB), .memDataB(memDataB),
    .chanA(chanA), .chanB(chanB), .altSel(altSel)
  );

  logic [20:0] memA [64];
  logic [20:0] memB [64];

  always @(posedge clk) begin
    if (memRdA) memDataA <= memA[memAddrA];
    if (memRdB) memDataB <= memB[memAddrB];
  end

  int vectors = 0, fails = 0;
  bit finished = 0;

  function automatic logic [20:0] rec(bit e, int ph, int lv);
    logic [11:0] p = ph[11:0];
    logic [7:0]  l = lv[7:0];
    return {e, p, l};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int   mIdx [2];
  bit   mSel, mPend;
  logic [7:0] mChanA, mChanB;

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx[0] = 0; mIdx[1] = 0; mSel = 0; mPend = 0; mChanA = 0; mChanB = 0;
    end else begin
      bit altRun, en[2], go[2], hit[2], lastOf[2];
      logic [20:0] r[2];
      altRun = altMode && runA;
      if (altMode) begin
        en[0] = altRun && (!mSel || mPend); en[1] = altRun && (mSel || mPend);
        go[0] = altRun && !mSel;            go[1] = altRun && mSel;
      end else begin
        en[0] = runA; en[1] = runB; go[0] = runA; go[1] = runB;
      end
      r[0] = memA[mIdx[0]]; r[1] = memB[mIdx[1]];
      for (int i = 0; i < 2; i++) begin
        hit[i]    = go[i] && phaseStep && (r[i][19:8] == phaseIdx);
        lastOf[i] = hit[i] && r[i][20];
      end
      if (altMode) begin
        if (mSel ? hit[1] : hit[0]) mChanA = mSel ? r[1][7:0] : r[0][7:0];
        mChanB = 0;
      end else begin
        if (hit[0]) mChanA = r[0][7:0];
        if (hit[1]) mChanB = r[1][7:0];
      end
      for (int i = 0; i < 2; i++)
        if (hit[i]) mIdx[i] = r[i][20] ? 0 : (mIdx[i] + 1) % 64;
      if (!altRun) begin
        mSel = 0; mPend = 0;
      end else if (mPend && (mSel ? lastOf[1] : lastOf[0])) begin
        mSel = !mSel; mPend = 0;
      end else if (switchReq) mPend = 1;
      for (int i = 0; i < 2; i++) if (!en[i]) mIdx[i] = 0;
    end
  end

  // compare every cycle away from the active edge (R4, R9)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(chanA === mChanA, "R4 chanA per-cycle", chanA, mChanA);
      chk(chanB === mChanB, "R4 chanB per-cycle", chanB, mChanB);
      chk(altSel === mSel, "R9 altSel per-cycle", altSel, mSel);
    end
  end

  // ---------------- stimulus ----------------
  task automatic stepTo(input int p);
    @(negedge clk); phaseIdx = p[11:0]; phaseStep = 1'b1;
    @(negedge clk); phaseStep = 1'b0;
  endtask

  task automatic pulseSwitch();
    @(negedge clk); switchReq = 1'b1;
    @(negedge clk); switchReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin memA[i] = '0; memB[i] = '0; end
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk(chanA == 0 && chanB == 0, "R2 reset outputs", {chanA, chanB}, 0);
    chk(altSel == 0 && !memRdA && !memRdB, "R2 reset quiet", {altSel, memRdA, memRdB}, 0);

    // independent mode
    memA[0] = rec(0, 10, 'h11); memA[1] = rec(0, 11, 'h22); memA[2] = rec(1, 20, 'h33);
    memB[0] = rec(0, 5, 'hA5);  memB[1] = rec(1, 7, 'h5A);
    @(negedge clk); runA = 1; runB = 1; #1;
    chk(memRdA && memAddrA == 0, "R3 first read address 0", {memRdA, memAddrA}, 'h40);
    @(negedge clk);
    chk(!memRdA, "R3 one read in flight", memRdA, 0);
    idle(6);
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p <= 30; p++) begin
        stepTo(p);
        if (pass == 0 && p == 10) chk(chanA == 'h11, "R4 apply level", chanA, 'h11);
        if (pass == 0 && p == 11) chk(chanA == 'h22, "R5 adjacent step applied", chanA, 'h22);
        if (pass == 0 && p == 20) chk(chanA == 'h33, "R1 end-flagged record fields", chanA, 'h33);
        if (pass == 0 && p == 7)  chk(chanB == 'h5A && chanA == 'h00, "R7 groups independent", {chanA, chanB}, 'h5A);
        if (pass == 1 && p == 10) chk(chanA == 'h11, "R6 wrap to address 0", chanA, 'h11);
      end
    end
    // no step: matching index held without strobe
    @(negedge clk); phaseIdx = 12'd10; idle(3);
    chk(chanA == 'h33, "R12 no strobe no change", chanA, 'h33);
    stepTo(12);
    chk(chanA == 'h33, "R12 unmatched step", chanA, 'h33);

    // stop and restart
    stepTo(10); stepTo(11);
    chk(chanA == 'h22, "R4 advance before stop", chanA, 'h22);
    @(negedge clk); runA = 0; idle(2);
    chk(!memRdA, "R13 stopped player quiet", memRdA, 0);
    runA = 1; #1;
    chk(memRdA && memAddrA == 0, "R13 restart at address 0", {memRdA, memAddrA}, 'h40);
    idle(6);
    stepTo(20);
    chk(chanA == 'h22, "R13 position discarded", chanA, 'h22);
    stepTo(10);
    chk(chanA == 'h11, "R13 replay from first record", chanA, 'h11);

    // alternate mode
    @(negedge clk); runA = 0; runB = 0;
    @(negedge clk); altMode = 1;
    memA[0] = rec(0, 100, 'h01); memA[1] = rec(0, 200, 'h02); memA[2] = rec(1, 300, 'h03);
    memB[0] = rec(0, 150, 'hF0); memB[1] = rec(1, 250, 'h0F);
    @(negedge clk); runA = 1; runB = 1;
    idle(6);
    chk(chanB == 0 && altSel == 0, "R8 pair starts on player 0", {altSel, chanB}, 0);
    chk(!memRdB, "R8 runB ignored", memRdB, 0);
    stepTo(100);
    chk(chanA == 'h01, "R8 player 0 drives group A", chanA, 'h01);
    pulseSwitch();
    pulseSwitch();
    idle(4);
    stepTo(150);
    chk(chanA == 'h01, "R9 standby silent before handover", chanA, 'h01);
    stepTo(200);
    chk(chanA == 'h02 && altSel == 0, "R9 handover deferred", {altSel, chanA}, 'h02);
    stepTo(300);
    chk(chanA == 'h03 && altSel == 1, "R9 handover after end record", {altSel, chanA}, 'h103);
    stepTo(150);
    chk(chanA == 'hF0, "R10 new player plays its segment", chanA, 'hF0);
    stepTo(250);
    chk(altSel == 1, "R11 second request absorbed", altSel, 1);
    // refill segment of player 0, then switch back
    memA[0] = rec(1, 120, 'h77);
    pulseSwitch();
    idle(4);
    stepTo(120);
    chk(chanA == 'h0F, "R9 standby ignores its event", chanA, 'h0F);
    stepTo(150); stepTo(250);
    chk(altSel == 0, "R9 switched back", altSel, 0);
    stepTo(120);
    chk(chanA == 'h77, "R10 fresh contents after reload", chanA, 'h77);
    @(negedge clk); runA = 0; idle(2);
    chk(altSel == 0 && !memRdA && !memRdB, "R13 pair stopped", {altSel, memRdA, memRdB}, 0);

    idle(2);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule